// File: doc/BRIEF.md
# I2C Slave Engine with General Call Recognition

This block is the bus-facing half of an I2C target device. It watches the open-drain SCL and SDA lines and passes both through a synchroniser and a majority filter, sampled at a rate the host chooses. From the filtered lines it detects START and STOP conditions and shifts in the address byte. It compares that byte with a programmable 7-bit own address and with the broadcast general call address. On a match it acknowledges, then moves data bytes in whichever direction the R/W bit selects. It drives the bus only through pull-low enables.

Received bytes leave on a valid/ready stream. The byte stays on `rx_data` with `rx_valid` high until the host raises `rx_ready`. While the byte waits, the engine holds SCL low, so a slow host throttles the bus rather than losing data. At that handshake the host also chooses, through `rx_nack`, whether the ninth clock is an ACK or a NACK. Bytes to transmit enter on a second valid/ready stream: `tx_ready` is high while the engine holds SCL low and waits for the next byte, and the byte is taken in the cycle that `tx_valid` and `tx_ready` are both high.

A general call raises its own interrupt and status code, separate from an own-address hit, so firmware can interpret the broadcast bytes that follow.

Top module: `i2c_gc_slave`

## Requirements
- R1: During and after reset, `scl_oe`, `sda_oe`, `rx_valid`, `tx_ready`, `irq_own` and `irq_gc` are 0 and `st_code` is 0.
- R2: An address byte whose upper seven bits equal `cfg_own_addr` is acknowledged (SDA pulled low on the ninth clock). It pulses `irq_own` for one cycle and sets `st_code` to 1 when R/W (bit 0) is 0, or to 2 when R/W is 1.
- R3: With `cfg_gc_en`=1, the address byte 00h is acknowledged. It pulses `irq_gc`, never together with `irq_own`, and sets `st_code` to 3.
- R4: With `cfg_gc_en`=0, the address byte 00h is not acknowledged, raises no interrupt, and the data bytes after it are neither acknowledged nor presented on `rx_valid`.
- R5: An address byte that matches neither the own address nor an enabled general call is not acknowledged. The bytes after it are ignored until the next START.
- R6: After an acknowledged write address, each data byte is shifted in MSB first on SCL rising edges and presented on `rx_data` with `rx_valid`. SCL is held low, and `rx_data` is stable, until the cycle in which `rx_ready` is high.
- R7: When `rx_nack`=1 at the receive handshake, SDA is left released on the ninth clock. Otherwise SDA is pulled low on the ninth clock.
- R8: After a general call, the engine acts as a receiver for the following bytes. The address byte 01h (all zero, R/W=1) is not treated as a general call.
- R9: After an acknowledged read address, and after each byte the master acknowledges, SCL is held low with `tx_ready`=1 until `tx_valid`. The accepted byte is then driven MSB first, each bit changing only while SCL is low.
- R10: A NACK from the master on the ninth clock of a transmitted byte releases SDA. It also keeps `tx_ready` low until the next START.
- R11: A START (SDA falling while SCL is high) restarts address reception from any state, including in the middle of a byte. A STOP (SDA rising while SCL is high) returns the engine to idle with `st_code`=0. A START also clears `st_code` to 0.
- R12: The filters take one sample every `cfg_sample_div`+1 system clocks. The protocol works unchanged at any divider that keeps the filter latency below the master's SCL low time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_own_addr | input | 7 | Own device address |
| cfg_gc_en | input | 1 | 1 = acknowledge general call address 00h |
| cfg_sample_div | input | DIV_W | Filter sample period minus one, in system clocks |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 = pull SCL low (clock stretch) |
| sda_oe | output | 1 | 1 = pull SDA low |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Host takes the received byte |
| rx_data | output | 8 | Received byte |
| rx_nack | input | 1 | With `rx_ready`: 1 = decline the byte (NACK) |
| tx_valid | input | 1 | Host offers the next byte to send |
| tx_ready | output | 1 | Engine waiting for a byte to send |
| tx_data | input | 8 | Byte to send |
| irq_own | output | 1 | One-cycle pulse on an own-address match |
| irq_gc | output | 1 | One-cycle pulse on a general call |
| st_code | output | 2 | 0 idle, 1 own write, 2 own read, 3 general call |

## Verification
The acknowledge decision for each byte is made at the eighth SCL falling edge, plus the synchroniser and filter latency. It is read by the bus model at mid-high of the ninth clock, long after it settles. Interrupt pulses come one cycle after the address decision and are counted on falling system-clock edges, so a one-cycle pulse is never missed. Status is sampled only after the whole address byte is done. Clock stretching is checked by the host model at the end of its random stall. By then the master has already released SCL, so a low line can only come from the engine. The data handshake is checked in the same falling-edge window.

// File: rtl/i2c_gcs_pkg.sv
package i2c_gcs_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  localparam logic [1:0] CODE_IDLE = 2'd0;
  localparam logic [1:0] CODE_WR   = 2'd1;
  localparam logic [1:0] CODE_RD   = 2'd2;
  localparam logic [1:0] CODE_GC   = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_RX,
    S_RXHOLD,
    S_RXACK,
    S_TXLOAD,
    S_TX
  } eng_state_e;
endpackage

// File: rtl/i2c_gcs_filt.sv
module i2c_gcs_filt (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic d,
  output logic q
);
  logic s1, s2;
  logic [2:0] hist;
  logic [2:0] nxt;

  assign nxt = {hist[1:0], s2};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      hist <= 3'b111;
      q    <= 1'b1;
    end else begin
      s1 <= d;
      s2 <= s1;
      if (tick) begin
        hist <= nxt;
        q    <= (nxt[0] & nxt[1]) | (nxt[0] & nxt[2]) | (nxt[1] & nxt[2]);
      end
    end
  end
endmodule

// File: rtl/i2c_gcs_fsm.sv
module i2c_gcs_fsm
  import i2c_gcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              scl,
  input  logic              sda,
  input  logic [ADDR_W-1:0] cfg_own_addr,
  input  logic              cfg_gc_en,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              rx_nack,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              irq_own,
  output logic              irq_gc,
  output logic [1:0]        st_code
);
  eng_state_e        state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              scl_q, sda_q;
  logic              rd_mode, mack;
  logic              rise, fall, start_ev, stop_ev;
  logic              own_hit, gc_hit;

  assign rise     = tick & scl & ~scl_q;
  assign fall     = tick & ~scl & scl_q;
  assign start_ev = tick & scl & scl_q & sda_q & ~sda;
  assign stop_ev  = tick & scl & scl_q & ~sda_q & sda;
  assign own_hit  = (shreg[BYTE_W-1:1] == cfg_own_addr);
  assign gc_hit   = cfg_gc_en && (shreg == '0);

  assign rx_valid = (state == S_RXHOLD);
  assign tx_ready = (state == S_TXLOAD);
  assign rx_data  = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      shreg   <= '0;
      cnt     <= '0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      rd_mode <= 1'b0;
      mack    <= 1'b0;
      irq_own <= 1'b0;
      irq_gc  <= 1'b0;
      st_code <= CODE_IDLE;
    end else begin
      irq_own <= 1'b0;
      irq_gc  <= 1'b0;
      if (tick) begin
        scl_q <= scl;
        sda_q <= sda;
      end
      if (start_ev || stop_ev) begin
        state   <= start_ev ? S_ADDR : S_IDLE;
        cnt     <= '0;
        scl_oe  <= 1'b0;
        sda_oe  <= 1'b0;
        st_code <= CODE_IDLE;
      end else begin
        unique case (state)
          S_IDLE: ;
          S_ADDR, S_RX: begin
            if (rise && cnt != CNT_W'(BYTE_W)) begin
              shreg <= {shreg[BYTE_W-2:0], sda};
              cnt   <= cnt + CNT_W'(1);
            end else if (fall && cnt == CNT_W'(BYTE_W)) begin
              if (state == S_RX) begin
                scl_oe <= 1'b1;
                state  <= S_RXHOLD;
              end else if (own_hit) begin
                sda_oe  <= 1'b1;
                rd_mode <= shreg[0];
                st_code <= shreg[0] ? CODE_RD : CODE_WR;
                irq_own <= 1'b1;
                state   <= S_AACK;
              end else if (gc_hit) begin
                sda_oe  <= 1'b1;
                rd_mode <= 1'b0;
                st_code <= CODE_GC;
                irq_gc  <= 1'b1;
                state   <= S_AACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_AACK: begin
            if (fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              scl_oe <= rd_mode;
              state  <= rd_mode ? S_TXLOAD : S_RX;
            end
          end
          S_RXHOLD: begin
            if (rx_ready) begin
              sda_oe <= ~rx_nack;
              scl_oe <= 1'b0;
              state  <= S_RXACK;
            end
          end
          S_RXACK: begin
            if (fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= S_RX;
            end
          end
          S_TXLOAD: begin
            if (tx_valid) begin
              shreg  <= tx_data;
              sda_oe <= ~tx_data[BYTE_W-1];
              scl_oe <= 1'b0;
              cnt    <= '0;
              state  <= S_TX;
            end
          end
          S_TX: begin
            if (cnt == CNT_W'(BYTE_W)) begin
              if (rise) begin
                mack <= ~sda;
              end else if (fall) begin
                scl_oe <= mack;
                state  <= mack ? S_TXLOAD : S_IDLE;
              end
            end else if (fall) begin
              cnt <= cnt + CNT_W'(1);
              if (cnt == CNT_W'(BYTE_W - 1)) begin
                sda_oe <= 1'b0;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_gc_slave.sv
module i2c_gc_slave
  import i2c_gcs_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_own_addr,
  input  logic              cfg_gc_en,
  input  logic [DIV_W-1:0]  cfg_sample_div,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              rx_nack,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              irq_own,
  output logic              irq_gc,
  output logic [1:0]        st_code
);
  localparam int NLINE = 2;

  logic [DIV_W-1:0] div_cnt;
  logic             tick;
  logic [NLINE-1:0] raw, filt;

  assign tick = (div_cnt >= cfg_sample_div);
  assign raw  = {sda_i, scl_i};

  always_ff @(posedge clk) begin
    if (rst || tick) div_cnt <= '0;
    else             div_cnt <= div_cnt + DIV_W'(1);
  end

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    i2c_gcs_filt u_filt (
      .clk (clk),
      .rst (rst),
      .tick(tick),
      .d   (raw[g]),
      .q   (filt[g])
    );
  end

  i2c_gcs_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .scl         (filt[0]),
    .sda         (filt[1]),
    .cfg_own_addr(cfg_own_addr),
    .cfg_gc_en   (cfg_gc_en),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_data     (rx_data),
    .rx_nack     (rx_nack),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .irq_own     (irq_own),
    .irq_gc      (irq_gc),
    .st_code     (st_code)
  );
endmodule

// File: rtl/i2c_gcs_chk.sv
module i2c_gcs_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_gc_en,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       tx_ready,
  input logic       irq_own,
  input logic       irq_gc,
  input logic [1:0] st_code
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !scl_oe && !sda_oe && !rx_valid && !tx_ready && !irq_own && !irq_gc && st_code == 2'd0);

  assert_own_code_R2: assert property (@(posedge clk) disable iff (rst)
    irq_own |-> (st_code == 2'd1 || st_code == 2'd2));

  assert_gc_code_R3: assert property (@(posedge clk) disable iff (rst)
    irq_gc |-> (st_code == 2'd3 && !irq_own));

  assert_gc_gated_R4: assert property (@(posedge clk) disable iff (rst)
    irq_gc |-> $past(cfg_gc_en));

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_rx_stretch_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> scl_oe);

  assert_tx_stretch_R9: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (scl_oe && !rx_valid));
endmodule

bind i2c_gc_slave i2c_gcs_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_gc_en(cfg_gc_en),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_data  (rx_data),
  .tx_ready (tx_ready),
  .irq_own  (irq_own),
  .irq_gc   (irq_gc),
  .st_code  (st_code)
);

// File: tb/test_i2c_gc_slave.sv
module test_i2c_gc_slave;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HP = 30;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] cfg_own_addr = 7'h11;
  logic       cfg_gc_en = 1'b1;
  logic [7:0] cfg_sample_div = 8'd1;
  logic       m_scl = 1'b0;
  logic       m_sda = 1'b0;
  logic       scl_bus, sda_bus;
  logic       scl_oe, sda_oe;
  logic       rx_valid, rx_ready, rx_nack;
  logic [7:0] rx_data;
  logic       tx_valid, tx_ready;
  logic [7:0] tx_data;
  logic       irq_own, irq_gc;
  logic [1:0] st_code;

  int n_chk = 0;
  int n_err = 0;
  int n_own = 0;
  int n_gc = 0;
  int rx_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  logic [7:0] tx_next = 8'h00;
  bit host_decl = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_bus = ~(m_scl | scl_oe);
  assign sda_bus = ~(m_sda | sda_oe);

  i2c_gc_slave i_i2c_gc_slave (
    .clk(clk), .rst(rst), .cfg_own_addr(cfg_own_addr), .cfg_gc_en(cfg_gc_en),
    .cfg_sample_div(cfg_sample_div), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_nack(rx_nack), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .irq_own(irq_own), .irq_gc(irq_gc), .st_code(st_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_ack(input logic [7:0] a);
    return (a[7:1] == cfg_own_addr) || (a == 8'h00 && cfg_gc_en);
  endfunction

  function automatic logic [1:0] exp_code(input logic [7:0] a);
    if (a[7:1] == cfg_own_addr) return a[0] ? 2'd2 : 2'd1;
    if (a == 8'h00 && cfg_gc_en) return 2'd3;
    return 2'd0;
  endfunction

  // host model: services both streams after a random stall
  initial begin
    int st;
    rx_ready = 1'b0; rx_nack = 1'b0; tx_valid = 1'b0; tx_data = 8'h00;
    forever begin
      @(negedge clk);
      if (!rst && rx_valid) begin
        st = 40 + int'($urandom % 50);
        repeat (st) @(negedge clk);
        chk(scl_bus == 1'b0, "R6 SCL held low while host stalls", scl_bus, 0);
        chk(rx_valid == 1'b1, "R6 rx_valid held until ready", rx_valid, 1);
        rx_last = rx_data;
        rx_cnt++;
        rx_nack = host_decl;
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        rx_nack = 1'b0;
      end else if (!rst && tx_ready) begin
        st = 40 + int'($urandom % 50);
        repeat (st) @(negedge clk);
        chk(scl_bus == 1'b0, "R9 SCL held low until tx byte", scl_bus, 0);
        tx_data = tx_next;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (irq_own) n_own++;
      if (irq_gc) n_gc++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic m_bit(input bit b, output bit r);
    m_sda = ~b;
    repeat (HP) @(negedge clk);
    m_scl = 1'b0;
    while (!scl_bus) @(negedge clk);
    repeat (HP/2) @(negedge clk);
    r = sda_bus;
    repeat (HP/2) @(negedge clk);
    m_scl = 1'b1;
    repeat (HP/4) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1;
    repeat (HP) @(negedge clk);
    m_scl = 1'b1;
    repeat (HP/4) @(negedge clk);
  endtask

  task automatic m_rstart();
    m_sda = 1'b0;
    repeat (HP) @(negedge clk);
    m_scl = 1'b0;
    while (!scl_bus) @(negedge clk);
    repeat (HP) @(negedge clk);
    m_start();
  endtask

  task automatic m_stop();
    m_sda = 1'b1;
    repeat (HP) @(negedge clk);
    m_scl = 1'b0;
    while (!scl_bus) @(negedge clk);
    repeat (HP) @(negedge clk);
    m_sda = 1'b0;
    repeat (2*HP) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic addr_phase(input logic [7:0] a, input bit rs, input string tag);
    int o0, g0;
    bit ack;
    logic [1:0] ec;
    o0 = n_own;
    g0 = n_gc;
    ec = exp_code(a);
    if (rs) m_rstart(); else m_start();
    wr_byte(a, ack);
    chk(ack == exp_ack(a), {tag, " address ACK"}, ack, exp_ack(a));
    chk(st_code == ec, {tag, " status code"}, st_code, ec);
    chk(n_own - o0 == int'(ec == 2'd1 || ec == 2'd2), {tag, " own interrupt"}, n_own - o0,
        int'(ec == 2'd1 || ec == 2'd2));
    chk(n_gc - g0 == int'(ec == 2'd3), {tag, " general call interrupt"}, n_gc - g0, int'(ec == 2'd3));
  endtask

  task automatic data_wr(input logic [7:0] d, input bit decl, input bit live, input string tag);
    int c0;
    bit ack;
    host_decl = decl;
    c0 = rx_cnt;
    wr_byte(d, ack);
    chk(ack == (live && !decl), {tag, " data ACK"}, ack, live && !decl);
    chk(rx_cnt - c0 == int'(live), {tag, " bytes delivered"}, rx_cnt - c0, int'(live));
    if (live) chk(rx_last == d, {tag, " received byte"}, rx_last, d);
    host_decl = 1'b0;
  endtask

  task automatic data_rd(input logic [7:0] d, input bit last, input string tag);
    logic [7:0] v;
    bit r;
    tx_next = d;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      v[i] = r;
    end
    m_bit(last, r);
    chk(v == d, {tag, " transmitted byte"}, v, d);
  endtask

  task automatic after_nack(input string tag);
    bit bad;
    bad = 1'b0;
    repeat (200) begin
      @(negedge clk);
      if (tx_ready || sda_oe) bad = 1'b1;
    end
    chk(!bad, {tag, " released after master NACK"}, bad, 0);
  endtask

  task automatic own_rounds(input int n, input string tag);
    int nb;
    for (int k = 0; k < n; k++) begin
      addr_phase({cfg_own_addr, 1'b0}, 1'b0, tag);
      nb = 1 + int'($urandom % 3);
      for (int j = 0; j < nb; j++) data_wr(8'($urandom), bit'($urandom % 3 == 0), 1'b1, "R7");
      m_stop();
      chk(st_code == 2'd0, "R11 status after STOP", st_code, 0);
      addr_phase({cfg_own_addr, 1'b1}, 1'b0, tag);
      nb = 1 + int'($urandom % 2);
      for (int j = 0; j < nb; j++) data_rd(8'($urandom), j == nb - 1, "R9");
      after_nack("R10");
      m_stop();
    end
  endtask

  initial begin
    bit r;
    void'($urandom(32'd20240611));
    cfg_own_addr = 7'(1 + ($urandom % 126));
    repeat (10) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R1 bus released in reset", {scl_oe, sda_oe}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(rx_valid == 0 && tx_ready == 0, "R1 streams idle after reset", {rx_valid, tx_ready}, 0);
    chk(st_code == 2'd0 && irq_own == 0 && irq_gc == 0, "R1 status idle after reset", st_code, 0);

    own_rounds(5, "R2");

    // general call enabled, then a declined byte and an accepted byte
    addr_phase(8'h00, 1'b0, "R3");
    data_wr(8'($urandom), 1'b1, 1'b1, "R7 general call declined");
    data_wr(8'($urandom), 1'b0, 1'b1, "R8 general call receiver");
    m_stop();

    // all-zero address with read bit is not a general call
    addr_phase(8'h01, 1'b0, "R8");
    data_wr(8'h5A, 1'b0, 1'b0, "R8");
    m_stop();

    // general call disabled
    cfg_gc_en = 1'b0;
    addr_phase(8'h00, 1'b0, "R4");
    data_wr(8'hC3, 1'b0, 1'b0, "R4");
    m_stop();
    cfg_gc_en = 1'b1;

    // foreign address
    addr_phase({cfg_own_addr ^ 7'h05, 1'b0}, 1'b0, "R5");
    data_wr(8'h96, 1'b0, 1'b0, "R5");
    m_stop();

    // repeated START after a byte and in the middle of a byte
    addr_phase({cfg_own_addr, 1'b0}, 1'b0, "R11");
    data_wr(8'hA5, 1'b0, 1'b1, "R11");
    m_bit(1'b1, r);
    m_bit(1'b0, r);
    m_bit(1'b1, r);
    addr_phase({cfg_own_addr, 1'b0}, 1'b1, "R11 restart");
    data_wr(8'h3C, 1'b0, 1'b1, "R11 restart");
    m_stop();
    chk(st_code == 2'd0, "R11 status after STOP", st_code, 0);

    // slower sampling rate
    cfg_sample_div = 8'd3;
    own_rounds(1, "R12");
    cfg_sample_div = 8'd1;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule